// File: doc/BRIEF.md
# Cyclic Row Scroll Offset Mapper

This block holds a scroll offset and uses it to turn the scan row index produced by the frame timing logic into the display RAM row that has to be read for that scan line. Each scroll command pulse moves the offset by one position. The direction input sets whether it moves up or down. The offset wraps within the number of scrolled rows. That number is 64 in full-height mode and 32 in half-height mode. Because only the read mapping changes, the RAM contents stay as they are, and the n-th row read still drives output row n.

The last scan line of every frame always reads the fixed extra bank row, and that row is never shifted by the offset. The mapped address is registered. The frame timing logic therefore sees the RAM row one clock after it presents the scan index. The current offset is also exposed as a registered output.

Top module: `row_scroll_mapper`

## Requirements
- R1: A synchronous reset sets `offset_o` to 0 and `ram_row_o` to 0.
- R2: When `scroll_i` is 1 and `dir_i` is 0, the offset increases by one at the clock edge.
- R3: When `scroll_i` is 1 and `dir_i` is 1, the offset decreases by one at the clock edge.
- R4: In full-height mode (`half_mode_i` = 0), the offset wraps between 63 and 0 in both directions. After 64 increments it is back at its starting value.
- R5: In half-height mode (`half_mode_i` = 1), the offset wraps between 31 and 0 in both directions. After 32 increments it is back at its starting value.
- R6: For a scan index r below N, where N is 64 in full-height mode and 32 in half-height mode, `ram_row_o` becomes (r + offset) mod N one clock later. The offset used is the value held before that edge.
- R7: For a scan index of N or above, `ram_row_o` becomes the fixed row 64 one clock later, whatever the offset.
- R8: While `half_mode_i` is 1, the stored offset is reduced modulo 32 at the next clock edge.
- R9: When reset and a scroll command arrive in the same cycle, the reset wins and the offset becomes 0.
- R10: When `scroll_i` is 0, the offset keeps its value, apart from the reduction in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| scroll_i | input | 1 | One-cycle scroll command |
| dir_i | input | 1 | Scroll direction: 0 increments, 1 decrements |
| half_mode_i | input | 1 | 0 selects full height (64 scrolled rows), 1 selects half height (32) |
| scan_row_i | input | 7 | Scan row index from the frame timing logic |
| ram_row_o | output | 7 | RAM row to read, registered |
| offset_o | output | 6 | Current scroll offset |

## Verification
The hardest state to reach is an offset whose upper bit is set at the moment the mode switches to half height. Only then can a missing modulo reduction, or a mapping that ignores the mode, produce a wrong address. The stimulus decrements from zero to reach 63, then switches mode on a cycle that also reads scan row 31. That cycle needs both the masked offset and the masked sum to come out right. Full laps of 64 and 32 commands, and a reset issued together with a scroll command, are driven as separate directed sequences.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } scroll_dir_e;

  // Mask of valid offset bits for the selected height mode.
  function automatic logic [5:0] height_mask(input logic half);
    return half ? 6'h1F : 6'h3F;
  endfunction
endpackage

// File: rtl/scroll_offset_reg.sv
module scroll_offset_reg #(
  parameter int ROW_BITS = 6
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                scroll_i,
  input  logic                dir_i,
  input  logic                half_mode_i,
  output logic [ROW_BITS-1:0] off_o
);
  import scroll_pkg::*;

  localparam logic [ROW_BITS-1:0] FULL_MASK = {ROW_BITS{1'b1}};
  localparam logic [ROW_BITS-1:0] HALF_MASK = {1'b0, {(ROW_BITS-1){1'b1}}};

  logic [ROW_BITS-1:0] off_q, mask, stepped;

  always_comb begin
    mask = half_mode_i ? HALF_MASK : FULL_MASK;
    if (!scroll_i)
      stepped = off_q;
    else if (scroll_dir_e'(dir_i) == DIR_DOWN)
      stepped = off_q + 1'b1;
    else
      stepped = off_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) off_q <= '0;
    else       off_q <= stepped & mask;
  end

  assign off_o = off_q;

  assert_inc_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (scroll_i && !dir_i && !half_mode_i) |=> off_q == $past(off_q) + 1'b1);
  assert_dec_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (scroll_i && dir_i && !half_mode_i) |=> off_q == $past(off_q) - 1'b1);
  assert_half_range_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    half_mode_i |=> off_q[ROW_BITS-1] == 1'b0);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!scroll_i && !half_mode_i) |=> $stable(off_q));
  assert_reset_R9: assert property (@(posedge clk_i)
    rst_i |=> off_q == '0);
endmodule

// File: rtl/row_addr_map.sv
module row_addr_map #(
  parameter int ROW_BITS = 6
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                half_mode_i,
  input  logic [ROW_BITS:0]   scan_i,
  input  logic [ROW_BITS-1:0] off_i,
  output logic [ROW_BITS:0]   addr_o
);
  localparam logic [ROW_BITS:0] FULL_N    = ROW_BITS'(0) | (1 << ROW_BITS);
  localparam logic [ROW_BITS:0] HALF_N    = (1 << (ROW_BITS-1));
  localparam logic [ROW_BITS:0] FIXED_ROW = FULL_N;
  localparam logic [ROW_BITS-1:0] FULL_MASK = {ROW_BITS{1'b1}};
  localparam logic [ROW_BITS-1:0] HALF_MASK = {1'b0, {(ROW_BITS-1){1'b1}}};

  logic [ROW_BITS:0]   limit;
  logic [ROW_BITS-1:0] mask, sum;
  logic [ROW_BITS:0]   addr_d, addr_q;

  always_comb begin
    limit  = half_mode_i ? HALF_N : FULL_N;
    mask   = half_mode_i ? HALF_MASK : FULL_MASK;
    sum    = (scan_i[ROW_BITS-1:0] + off_i) & mask;
    addr_d = (scan_i >= limit) ? FIXED_ROW : {1'b0, sum};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) addr_q <= '0;
    else       addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  assert_fixed_row_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (scan_i >= (half_mode_i ? HALF_N : FULL_N)) |=> addr_q == FIXED_ROW);
  assert_in_window_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (scan_i < (half_mode_i ? HALF_N : FULL_N)) |=>
      addr_q < ($past(half_mode_i) ? HALF_N : FULL_N));
  assert_reset_R1: assert property (@(posedge clk_i)
    rst_i |=> addr_q == '0);
endmodule

// File: rtl/row_scroll_mapper.sv
module row_scroll_mapper #(
  parameter int ROW_BITS = 6
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                scroll_i,
  input  logic                dir_i,
  input  logic                half_mode_i,
  input  logic [ROW_BITS:0]   scan_row_i,
  output logic [ROW_BITS:0]   ram_row_o,
  output logic [ROW_BITS-1:0] offset_o
);
  logic [ROW_BITS-1:0] off;

  scroll_offset_reg #(.ROW_BITS(ROW_BITS)) u_off (
    .clk_i(clk_i), .rst_i(rst_i), .scroll_i(scroll_i), .dir_i(dir_i),
    .half_mode_i(half_mode_i), .off_o(off)
  );

  row_addr_map #(.ROW_BITS(ROW_BITS)) u_map (
    .clk_i(clk_i), .rst_i(rst_i), .half_mode_i(half_mode_i),
    .scan_i(scan_row_i), .off_i(off), .addr_o(ram_row_o)
  );

  assign offset_o = off;
endmodule

// File: tb/sim_row_scroll_mapper.sv
module sim_row_scroll_mapper;
  logic clk = 0, rst = 1, scroll = 0, dir = 0, half = 0;
  logic [6:0] scan = '0;
  logic [6:0] ram_row;
  logic [5:0] offset;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  row_scroll_mapper u0 (
    .clk_i(clk), .rst_i(rst), .scroll_i(scroll), .dir_i(dir),
    .half_mode_i(half), .scan_row_i(scan), .ram_row_o(ram_row), .offset_o(offset)
  );

  typedef struct packed {
    logic       s;
    logic       d;
    logic       h;
    logic [6:0] scan;
    logic [5:0] off;
    logic [6:0] addr;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b1, 1'b0, 1'b0, 7'd0,  6'd1,  7'd0 },  // R2 R6
    '{1'b1, 1'b0, 1'b0, 7'd5,  6'd2,  7'd6 },  // R2 R6
    '{1'b0, 1'b0, 1'b0, 7'd63, 6'd2,  7'd1 },  // R6 R10
    '{1'b0, 1'b0, 1'b0, 7'd64, 6'd2,  7'd64},  // R7
    '{1'b1, 1'b1, 1'b0, 7'd10, 6'd1,  7'd12},  // R3
    '{1'b1, 1'b1, 1'b0, 7'd0,  6'd0,  7'd1 },  // R3
    '{1'b1, 1'b1, 1'b0, 7'd0,  6'd63, 7'd0 },  // R4
    '{1'b0, 1'b0, 1'b0, 7'd1,  6'd63, 7'd0 },  // R4 R6
    '{1'b0, 1'b0, 1'b1, 7'd31, 6'd31, 7'd30},  // R8 R6
    '{1'b1, 1'b0, 1'b1, 7'd32, 6'd0,  7'd64},  // R5 R7
    '{1'b1, 1'b1, 1'b1, 7'd3,  6'd31, 7'd3 },  // R5
    '{1'b0, 1'b0, 1'b1, 7'd40, 6'd31, 7'd64},  // R7
    '{1'b0, 1'b0, 1'b0, 7'd0,  6'd31, 7'd31}   // R6 R10
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick; tick;
    rst = 0; #1;
    check("R1 offset", offset, 0);
    check("R1 row", ram_row, 0);

    foreach (VEC[i]) begin
      scroll = VEC[i].s; dir = VEC[i].d; half = VEC[i].h; scan = VEC[i].scan;
      tick;
      check($sformatf("R2-vec%0d offset", i), offset, VEC[i].off);
      check($sformatf("R6-vec%0d row", i), ram_row, VEC[i].addr);
    end
    scroll = 0;

    // R4: a full lap of 64 increments returns to the start
    half = 0; dir = 0;
    for (int k = 0; k < 64; k++) begin scroll = 1; tick; end
    scroll = 0; tick;
    check("R4 lap64", offset, 31);

    // R5: a lap of 32 increments in half mode
    half = 1;
    for (int k = 0; k < 32; k++) begin scroll = 1; tick; end
    scroll = 0; tick;
    check("R5 lap32", offset, 31);
    scroll = 1; dir = 0; tick; scroll = 0;
    check("R5 wrap31to0", offset, 0);

    // R9: reset together with a scroll command
    half = 0; scroll = 1; dir = 0; tick; tick;
    check("R9 pre", offset, 2);
    rst = 1; scroll = 1; tick;
    check("R9 reset wins", offset, 0);
    check("R1 row after reset", ram_row, 0);
    rst = 0; scroll = 0; scan = 7'd20; tick;
    check("R10 hold", offset, 0);
    check("R6 zero offset", ram_row, 20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule